// File: doc/BRIEF.md
# Debug Monitor Mode Entry Controller

This block makes the boot-mode decision for a small microcontroller. When reset is released, it looks at three things: a synchronized flag from the comparator that detects a high test voltage on the interrupt pin, the logic level of that pin, and the reset vector word read from memory. From these it picks user mode or a serial debug monitor mode. It keeps that choice until the next reset. Monitor mode can be reached in two ways:

- **Voltage-entered:** the high voltage is present at release.
- **Forced:** no high voltage is present, but the reset vector reads as blank (all ones).

The two kinds of monitor mode gate the watchdog differently and route the pins differently. Both move the reset, break and software-interrupt vector fetches from page 0xFF to page 0xFE.

The state machine has five states:

- `ST_RESET`: held while either reset is low.
- `ST_USER`: normal operation.
- `ST_MON_HV`: voltage-entered monitor mode, with the high voltage still present.
- `ST_MON_CFG`: voltage-entered monitor mode after the voltage has dropped.
- `ST_MON_FORCED`: monitor mode forced by a blank vector.

The transitions are:

- On the first clock edge after release, `ST_RESET` moves to `ST_MON_HV` if the synchronized voltage flag is set. Otherwise it moves to `ST_MON_FORCED` if the vector is blank. Otherwise it moves to `ST_USER`.
- `ST_MON_HV` moves to `ST_MON_CFG` when the synchronized flag falls.
- Every state returns to `ST_RESET` when reset is asserted.

When monitor mode is entered with a blank vector, the block asks for one extra reset, a pulse of fixed length. This happens only once per power-on.

Top module: `mon_entry_ctrl`

## Requirements
- R1: While `rst_n` or `por_n` is low, every mode and pin-select output is 0 and `extra_rst` does not start. The selected mode does not change until the next reset.
- R2: At the first rising clock edge after reset release, the controller picks a mode in this order of priority. If the synchronized high-voltage flag is set, it enters voltage monitor mode. Else, if `rst_vector` equals 0xFFFF, it enters forced monitor mode. Else it enters user mode.
- R3: In voltage monitor mode with the voltage still present, the outputs are `mon_mode`=1, `wdog_disable`=1, `pin_rst_alt`=1, `pin_osc_alt`=1 and `pin_ser_en`=1.
- R4: `hv_detect` passes through a two-flop synchronizer. A drop of the voltage moves the block to the post-drop state on the third rising edge after the drop. From that edge on:
  - `wdog_disable` is 0.
  - `mon_mode` stays 1.
  - `pin_rst_alt` and `pin_osc_alt` hold the `cfg_rst_alt` and `cfg_osc_alt` values sampled at that edge.
  - Later changes of the configuration inputs have no effect.
- R5: In forced monitor mode, the outputs are `wdog_disable`=1, `pin_ser_en`=1 and `pin_rst_alt`=0. `pin_osc_alt` equals the `irq_level` sampled at the decision edge, and later changes of `irq_level` have no effect.
- R6: `irq_port_en` is 1 in user mode and 0 in every monitor state.
- R7: In monitor mode, a `fetch_addr_in` in the range 0xFFFC to 0xFFFF has its upper byte replaced by 0xFE. This gives 0xFEFC/0xFEFD for break and SWI, and 0xFEFE/0xFEFF for reset. Every other address, and every address in user mode, passes through unchanged.
- R8: When monitor mode is entered with `rst_vector` equal to 0xFFFF, `extra_rst` is high for exactly 4 cycles, starting with the decision edge. It fires only once until `por_n` is asserted again.
- R9: In user mode, `pin_rst_alt` and `pin_osc_alt` follow `cfg_rst_alt` and `cfg_osc_alt` combinationally, `wdog_disable` is 0 and `pin_ser_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; also clears the extra-reset sticky flag |
| rst_n | input | 1 | Reset request, active low |
| hv_detect | input | 1 | Asynchronous high-test-voltage comparator flag |
| irq_level | input | 1 | Logic level of the interrupt pin |
| rst_vector | input | 16 | Reset vector word read from memory |
| cfg_rst_alt | input | 1 | Configuration bit: reset function on alternate pin |
| cfg_osc_alt | input | 1 | Configuration bit: oscillator input on alternate pin |
| fetch_addr_in | input | 16 | Address requested by the core |
| mon_mode | output | 1 | Monitor mode active |
| wdog_disable | output | 1 | Disables the watchdog |
| pin_rst_alt | output | 1 | Routes the reset function to its alternate pin |
| pin_osc_alt | output | 1 | Routes the oscillator input to its alternate pin |
| pin_ser_en | output | 1 | Enables the serial communication pin |
| irq_port_en | output | 1 | Allows the interrupt pin to act as a port input |
| extra_rst | output | 1 | Request for one additional reset |
| fetch_addr_out | output | 16 | Address after vector-page remapping |

## Verification
The hardest situation to reach is the post-drop monitor state. It needs a power-on, a high voltage held through the synchronizer before release, and then a drop timed to the cycle, followed by a change of the configuration inputs. The stimulus holds `hv_detect` for three cycles before releasing reset. It then drops the voltage just after a clock edge and checks `wdog_disable` on each of the following negative edges, so the three-edge latency is confirmed exactly. The once-per-power-on rule of the extra reset needs a further reset without power-on while the vector is still blank, and then a fresh power-on to show that the pulse returns.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

    typedef enum logic [2:0] {
        ST_RESET      = 3'd0,
        ST_USER       = 3'd1,
        ST_MON_HV     = 3'd2,
        ST_MON_CFG    = 3'd3,
        ST_MON_FORCED = 3'd4
    } mon_state_e;

    typedef struct packed {
        logic rst_alt;
        logic osc_alt;
    } pin_cfg_t;

endpackage

// File: rtl/mon_hv_sync.sv
module mon_hv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) shift_q <= '0;
                else        shift_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) shift_q <= '0;
                else        shift_q <= {shift_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = shift_q[STAGES-1];
endmodule

// File: rtl/mon_xrst_pulse.sv
module mon_xrst_pulse #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start && !done_q) begin
            cnt_q  <= CW'(CYCLES);
            done_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/mon_vec_remap.sv
module mon_vec_remap #(
    parameter int               AW       = 16,
    parameter int               LOW_W    = 8,
    parameter int               WIN_LSB  = 2,
    parameter logic [AW-LOW_W-1:0] MON_HI = 8'hFE
) (
    input  logic          mon_active,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    logic in_window;

    assign in_window = &addr_in[AW-1:WIN_LSB];

    always_comb begin
        if (mon_active && in_window) addr_out = {MON_HI, addr_in[LOW_W-1:0]};
        else                         addr_out = addr_in;
    end
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl #(
    parameter int AW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int XRST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          hv_detect,
    input  logic          irq_level,
    input  logic [AW-1:0] rst_vector,
    input  logic          cfg_rst_alt,
    input  logic          cfg_osc_alt,
    input  logic [AW-1:0] fetch_addr_in,
    output logic          mon_mode,
    output logic          wdog_disable,
    output logic          pin_rst_alt,
    output logic          pin_osc_alt,
    output logic          pin_ser_en,
    output logic          irq_port_en,
    output logic          extra_rst,
    output logic [AW-1:0] fetch_addr_out
);
    import mon_entry_pkg::*;

    localparam logic [AW-1:0] BLANK_VEC = '1;

    mon_state_e state_q, state_d;
    pin_cfg_t   cfg_cap_q;
    logic       forced_osc_q;
    logic       hv_s;
    logic       rst_all_n;
    logic       vec_blank;
    logic       xrst_start;

    assign rst_all_n = rst_n & por_n;
    assign vec_blank = (rst_vector == BLANK_VEC);

    mon_hv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .async_in (hv_detect),
        .sync_out (hv_s)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: begin
                if (hv_s)           state_d = ST_MON_HV;
                else if (vec_blank) state_d = ST_MON_FORCED;
                else                state_d = ST_USER;
            end
            ST_MON_HV:     if (!hv_s) state_d = ST_MON_CFG;
            ST_USER:       state_d = ST_USER;
            ST_MON_CFG:    state_d = ST_MON_CFG;
            ST_MON_FORCED: state_d = ST_MON_FORCED;
            default:       state_d = ST_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) state_q <= ST_RESET;
        else            state_q <= state_d;
    end

    // captures taken on transitions
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            cfg_cap_q    <= '0;
            forced_osc_q <= 1'b0;
        end else begin
            if (state_q == ST_MON_HV && !hv_s) begin
                cfg_cap_q.rst_alt <= cfg_rst_alt;
                cfg_cap_q.osc_alt <= cfg_osc_alt;
            end
            if (state_q == ST_RESET) forced_osc_q <= irq_level;
        end
    end

    assign xrst_start = (state_q == ST_RESET) && rst_all_n && vec_blank;

    mon_xrst_pulse #(.CYCLES(XRST_CYCLES)) u_xrst (
        .clk   (clk),
        .por_n (por_n),
        .start (xrst_start),
        .pulse (extra_rst)
    );

    // outputs per state
    always_comb begin
        mon_mode     = 1'b0;
        wdog_disable = 1'b0;
        pin_rst_alt  = 1'b0;
        pin_osc_alt  = 1'b0;
        pin_ser_en   = 1'b0;
        irq_port_en  = 1'b0;
        unique case (state_q)
            ST_RESET: ;
            ST_USER: begin
                pin_rst_alt = cfg_rst_alt;
                pin_osc_alt = cfg_osc_alt;
                irq_port_en = 1'b1;
            end
            ST_MON_HV: begin
                mon_mode     = 1'b1;
                wdog_disable = 1'b1;
                pin_rst_alt  = 1'b1;
                pin_osc_alt  = 1'b1;
                pin_ser_en   = 1'b1;
            end
            ST_MON_CFG: begin
                mon_mode    = 1'b1;
                pin_rst_alt = cfg_cap_q.rst_alt;
                pin_osc_alt = cfg_cap_q.osc_alt;
                pin_ser_en  = 1'b1;
            end
            ST_MON_FORCED: begin
                mon_mode     = 1'b1;
                wdog_disable = 1'b1;
                pin_osc_alt  = forced_osc_q;
                pin_ser_en   = 1'b1;
            end
            default: ;
        endcase
    end

    mon_vec_remap #(.AW(AW)) u_remap (
        .mon_active (mon_mode),
        .addr_in    (fetch_addr_in),
        .addr_out   (fetch_addr_out)
    );
endmodule

// File: rtl/mon_entry_chk.sv
module mon_entry_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          por_n,
    input logic          mon_mode,
    input logic          wdog_disable,
    input logic          irq_port_en,
    input logic          extra_rst,
    input logic          st_forced,
    input logic [AW-1:0] fetch_addr_in,
    input logic [AW-1:0] fetch_addr_out
);
    // R1: the selected mode persists until a reset
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        mon_mode |=> mon_mode);

    // R6: interrupt pin never a port input in monitor mode
    p_irq_port_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        mon_mode |-> !irq_port_en);

    // R5: forced monitor keeps the watchdog off
    p_forced_wdog_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        st_forced |-> wdog_disable);

    // R9: outside monitor mode the watchdog runs
    p_user_wdog_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !mon_mode |-> !wdog_disable);

    // R7: vector window moves to the monitor page
    p_remap_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (mon_mode && (&fetch_addr_in[AW-1:2])) |->
        (fetch_addr_out[AW-1:8] == 8'hFE && fetch_addr_out[7:0] == fetch_addr_in[7:0]));

    // R7: addresses outside page 0xFF are untouched
    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (fetch_addr_in[AW-1:8] != 8'hFF) |-> (fetch_addr_out == fetch_addr_in));

    // R8: the extra reset pulse lasts more than one cycle
    p_xrst_len_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(extra_rst) |=> extra_rst);
endmodule

bind mon_entry_ctrl mon_entry_chk #(.AW(AW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .por_n          (por_n),
    .mon_mode       (mon_mode),
    .wdog_disable   (wdog_disable),
    .irq_port_en    (irq_port_en),
    .extra_rst      (extra_rst),
    .st_forced      (state_q == mon_entry_pkg::ST_MON_FORCED),
    .fetch_addr_in  (fetch_addr_in),
    .fetch_addr_out (fetch_addr_out)
);

// File: tb/mon_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module mon_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        por_n, rst_n, hv_detect, irq_level, cfg_rst_alt, cfg_osc_alt;
    logic [15:0] rst_vector, fetch_addr_in, fetch_addr_out;
    logic        mon_mode, wdog_disable, pin_rst_alt, pin_osc_alt, pin_ser_en, irq_port_en, extra_rst;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        logic [22:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    mon_entry_ctrl dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .hv_detect(hv_detect),
        .irq_level(irq_level), .rst_vector(rst_vector), .cfg_rst_alt(cfg_rst_alt),
        .cfg_osc_alt(cfg_osc_alt), .fetch_addr_in(fetch_addr_in),
        .mon_mode(mon_mode), .wdog_disable(wdog_disable), .pin_rst_alt(pin_rst_alt),
        .pin_osc_alt(pin_osc_alt), .pin_ser_en(pin_ser_en), .irq_port_en(irq_port_en),
        .extra_rst(extra_rst), .fetch_addr_out(fetch_addr_out)
    );

    // bits: mon wdog rst_alt osc_alt ser irq_port xrst addr
    function automatic logic [22:0] ev(input logic m, input logic w, input logic ra, input logic oa,
                                       input logic se, input logic ip, input logic xr, input logic [15:0] a);
        return {m, w, ra, oa, se, ip, xr, a};
    endfunction

    // monitor: compares on the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [22:0] act;
            it  = sb_q.pop_front();
            act = {mon_mode, wdog_disable, pin_rst_alt, pin_osc_alt, pin_ser_en,
                   irq_port_en, extra_rst, fetch_addr_out};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_now(input string req, input logic [22:0] exp);
        sb_item_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        #1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic enter(input logic do_por);
        rst_n = 1'b0;
        if (do_por) por_n = 1'b0;
        tick(3);
        por_n = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; hv_detect = 1'b0; irq_level = 1'b0;
        rst_vector = 16'h1234; cfg_rst_alt = 1'b0; cfg_osc_alt = 1'b0;
        fetch_addr_in = 16'hFFFE;
        tick(3);
        expect_now("R1 reset state", ev(0,0,0,0,0,0,0,16'hFFFE));

        // user mode
        por_n = 1'b1; tick(3); rst_n = 1'b1; tick(1);
        expect_now("R2 user decision / R7 user passthrough", ev(0,0,0,0,0,1,0,16'hFFFE));
        cfg_rst_alt = 1'b1;
        expect_now("R9 user pins follow cfg", ev(0,0,1,0,0,1,0,16'hFFFE));
        cfg_rst_alt = 1'b0; cfg_osc_alt = 1'b1;
        expect_now("R6 R9 user irq port", ev(0,0,0,1,0,1,0,16'hFFFE));

        // voltage-entered monitor
        rst_n = 1'b0; hv_detect = 1'b1; tick(3);
        expect_now("R1 reset clears mode", ev(0,0,0,0,0,0,0,16'hFFFE));
        rst_n = 1'b1; tick(1);
        expect_now("R3 hv monitor / R7 reset vector", ev(1,1,1,1,1,0,0,16'hFEFE));
        fetch_addr_in = 16'hFFFC;
        expect_now("R7 break vector high", ev(1,1,1,1,1,0,0,16'hFEFC));
        fetch_addr_in = 16'hFFFF;
        expect_now("R7 reset vector low", ev(1,1,1,1,1,0,0,16'hFEFF));
        fetch_addr_in = 16'hFFFB;
        expect_now("R7 outside window", ev(1,1,1,1,1,0,0,16'hFFFB));
        fetch_addr_in = 16'h0100;
        expect_now("R7 other page", ev(1,1,1,1,1,0,0,16'h0100));

        // drop the voltage
        fetch_addr_in = 16'hFFFD;
        cfg_rst_alt = 1'b0; cfg_osc_alt = 1'b1;
        tick(1);
        hv_detect = 1'b0;
        expect_now("R4 drop edge 0", ev(1,1,1,1,1,0,0,16'hFEFD));
        tick(1);
        expect_now("R4 drop edge 1 sync", ev(1,1,1,1,1,0,0,16'hFEFD));
        tick(1);
        expect_now("R4 drop edge 2 sync", ev(1,1,1,1,1,0,0,16'hFEFD));
        tick(1);
        expect_now("R4 post-drop state", ev(1,0,0,1,1,0,0,16'hFEFD));
        cfg_rst_alt = 1'b1; cfg_osc_alt = 1'b0;
        tick(2);
        expect_now("R4 cfg change ignored", ev(1,0,0,1,1,0,0,16'hFEFD));

        // forced monitor with power-on
        rst_vector = 16'hFFFF; irq_level = 1'b1; fetch_addr_in = 16'hFFFE;
        enter(1'b1);
        expect_now("R5 forced irq high / R8 pulse 1", ev(1,1,0,1,1,0,1,16'hFEFE));
        tick(1);
        expect_now("R8 pulse 2", ev(1,1,0,1,1,0,1,16'hFEFE));
        irq_level = 1'b0;
        tick(1);
        expect_now("R8 pulse 3 / R5 irq change ignored", ev(1,1,0,1,1,0,1,16'hFEFE));
        tick(1);
        expect_now("R8 pulse 4", ev(1,1,0,1,1,0,1,16'hFEFE));
        tick(1);
        expect_now("R8 pulse end", ev(1,1,0,1,1,0,0,16'hFEFE));

        // reset without power-on: no second pulse
        enter(1'b0);
        expect_now("R8 once per power-on / R5 irq low", ev(1,1,0,0,1,0,0,16'hFEFE));
        tick(1);
        expect_now("R8 still no pulse", ev(1,1,0,0,1,0,0,16'hFEFE));

        // power-on with voltage and blank vector: voltage wins, pulse returns
        hv_detect = 1'b1;
        enter(1'b1);
        expect_now("R2 voltage priority / R8 pulse after new power-on", ev(1,1,1,1,1,0,1,16'hFEFE));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule